// File: doc/BRIEF.md
# Programmable Skew Clock Phase Selector

This block builds eight clock outputs, grouped as four pairs, from a fast time-base clock. The time base runs at N times the nominal output frequency, so one time-base period is one time unit. Every output period lasts N units, and N depends on a frequency-range select. A modulo-N phase counter advances on the time base. Each pair decodes its own phase window from the counter. The window can be shifted by a signed number of time units, or the pair can run at half or quarter rate, or as an inverted copy of the zero-skew clock.

Each pair has two three-level selects, called high and low, and each select is carried as a 2-bit code. The nine combinations give the pair its function. The first two pairs have fine one-unit steps. The last two pairs have coarse two-unit steps plus the divided and inverted functions. New settings take effect only at the zero point of the counter. A test select puts the block in bypass mode. In bypass mode, rising edges of the reference input advance the counter in place of the time base, and all relative output functions stay the same.

Top module: `skew_phase_sel`

## Requirements
- R1: While reset is low, all eight outputs are low. After reset the counter waits at its last count, so the first advance is a zero point: the zero-skew output goes high on the first time-base edge after reset is released.
- R2: The output period is N advances. The range code sets N: 00 gives 44, 01 gives 26, 10 gives 16, and 11 gives 26. The counter value always stays below N.
- R3: A pair set to zero skew (high = 01, low = 01) goes high when the counter reaches 0 and stays high for N/2 advances, which gives a 50% duty cycle.
- R4: On pairs 1 and 2, let idx = 3*level(high) + level(low), where level(00)=0, level(01)=1, level(10)=2 and level(11)=1. The output is offset by idx-4 units: it rises at count (idx-4) mod N and falls N/2 counts later.
- R5: On pairs 3 and 4, idx values 1 to 7 give an offset of 2*(idx-4) units, which is one of -6, -4, -2, 0, 2, 4, 6. The waveform is the same as in R4.
- R6: On pairs 3 and 4, idx 0 gives divide-by-2. The output is high for the output periods that have an even index and low for those with an odd index. Periods are counted from the first zero point after reset, starting at 0.
- R7: On pair 3, idx 8 gives divide-by-4. The output is high when the period index mod 4 is 0 or 3. Its falling edges coincide with falling edges of a divide-by-2 output.
- R8: On pair 4, idx 8 gives the inverse of the zero-skew waveform: the output is high from count N/2 to count N-1. It stays low in reset.
- R9: The two outputs of a pair always carry the same value.
- R10: The select codes and the range code are sampled only at a zero point. A change made in the middle of a period leaves the outputs unaffected until the counter next wraps to 0.
- R11: When the test code is not 00, the counter advances once for each rising edge of the reference input, as seen on the time base. Without such an edge the outputs hold their values. With test code 00 the counter advances on every time-base edge.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| tb_clk | input | 1 | Time-base clock, one period per time unit |
| rst_n | input | 1 | Asynchronous active-low reset |
| range_sel | input | 2 | Frequency-range code that picks N |
| test_sel | input | 2 | Test code; any value other than 00 selects bypass |
| ref_in | input | 1 | Reference input, used as the step source in bypass |
| pair_sel | input | 16 | Pair p (0..3) uses bits [4p+3:4p+2] for its high select and [4p+1:4p] for its low select |
| clk_out | output | 8 | Pair p drives bits 2p and 2p+1 |

## Verification
The bench builds the block with the default periods of 44, 26 and 16 units. With these values every range code gives a period short enough to measure end to end. It runs all nine function settings on every pair at each of the three periods, including the largest coarse offsets, which lie close to half of the shortest period. The short 16-unit period also makes the many divide-by-4 cycles needed to check the falling-edge alignment cheap, and makes bypass runs slowed by the reference input affordable.

// File: rtl/skew_sel_pkg.sv
package skew_sel_pkg;

   typedef logic [1:0] tri_code_t;

   typedef enum logic [1:0] {
      FN_SKEW = 2'd0,
      FN_DIV2 = 2'd1,
      FN_DIV4 = 2'd2,
      FN_INV  = 2'd3
   } pair_fn_e;

   typedef struct packed {
      pair_fn_e          fn;
      logic signed [3:0] ofs;
   } pair_cfg_t;

   localparam int KIND_FINE = 0;
   localparam int KIND_DIV4 = 1;
   localparam int KIND_INV  = 2;

   localparam pair_cfg_t CFG_ZERO = '{fn: FN_SKEW, ofs: 4'sd0};

   function automatic int tri_level(tri_code_t c);
      case (c)
         2'b00:   return 0;
         2'b10:   return 2;
         default: return 1;
      endcase
   endfunction

   function automatic pair_cfg_t decode_pair(int kind, tri_code_t hi, tri_code_t lo);
      pair_cfg_t r;
      int        idx;
      idx   = 3 * tri_level(hi) + tri_level(lo);
      r.fn  = FN_SKEW;
      r.ofs = 4'sd0;
      if (kind == KIND_FINE) begin
         r.ofs = 4'(idx - 4);
      end else if (idx == 0) begin
         r.fn = FN_DIV2;
      end else if (idx == 8) begin
         r.fn = (kind == KIND_DIV4) ? FN_DIV4 : FN_INV;
      end else begin
         r.ofs = 4'(2 * (idx - 4));
      end
      return r;
   endfunction

   function automatic int max3(int a, int b, int c);
      int m;
      m = (a > b) ? a : b;
      return (m > c) ? m : c;
   endfunction

endpackage

// File: rtl/skew_bypass_gate.sv
module skew_bypass_gate (
   input  logic       clk,
   input  logic       rst_n,
   input  logic [1:0] test_code,
   input  logic       ref_in,
   output logic       adv
);
   logic ref_q;
   logic bypass;

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) ref_q <= 1'b0;
      else        ref_q <= ref_in;
   end

   assign bypass = (test_code != 2'b00);
   assign adv    = bypass ? (ref_in & ~ref_q) : 1'b1;
endmodule

// File: rtl/skew_phase_ctr.sv
module skew_phase_ctr #(
   parameter int N_LOW  = 44,
   parameter int N_MID  = 26,
   parameter int N_HIGH = 16,
   parameter int CW     = 6
) (
   input  logic          clk,
   input  logic          rst_n,
   input  logic          adv,
   input  logic [1:0]    range_code,
   output logic [CW-1:0] cnt,
   output logic [CW-1:0] n_cur,
   output logic          zero_pt,
   output logic          live,
   output logic [1:0]    dcyc
);
   logic          wrap;
   logic [CW-1:0] n_sel;

   always_comb begin
      case (range_code)
         2'b00:   n_sel = CW'(N_LOW);
         2'b10:   n_sel = CW'(N_HIGH);
         default: n_sel = CW'(N_MID);
      endcase
   end

   assign wrap    = (cnt == n_cur - CW'(1));
   assign zero_pt = adv & wrap;

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         cnt   <= CW'(N_MID - 1);
         n_cur <= CW'(N_MID);
         live  <= 1'b0;
         dcyc  <= 2'd0;
      end else if (adv) begin
         live <= 1'b1;
         if (wrap) begin
            cnt   <= '0;
            n_cur <= n_sel;
            if (live) dcyc <= dcyc + 2'd1;
         end else begin
            cnt <= cnt + CW'(1);
         end
      end
   end
endmodule

// File: rtl/skew_pair_gen.sv
module skew_pair_gen
   import skew_sel_pkg::*;
#(
   parameter int KIND = KIND_FINE,
   parameter int CW   = 6
) (
   input  logic          clk,
   input  logic          rst_n,
   input  logic          load,
   input  tri_code_t     hi_code,
   input  tri_code_t     lo_code,
   input  logic [CW-1:0] cnt,
   input  logic [CW-1:0] n_cur,
   input  logic          live,
   input  logic [1:0]    dcyc,
   output logic          q
);
   localparam int EW = CW + 2;

   pair_cfg_t     cfg_q;
   logic [EW-1:0] ofs_x, n_x, sum, pos;
   logic [CW-1:0] half;
   logic          wave_skew, wave;

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n)    cfg_q <= CFG_ZERO;
      else if (load) cfg_q <= decode_pair(KIND, hi_code, lo_code);
   end

   assign half  = n_cur >> 1;
   assign n_x   = {2'b00, n_cur};
   assign ofs_x = {{(EW-4){cfg_q.ofs[3]}}, cfg_q.ofs};
   assign sum   = {2'b00, cnt} + n_x - ofs_x;

   always_comb begin
      if (sum >= (n_x << 1))  pos = sum - (n_x << 1);
      else if (sum >= n_x)    pos = sum - n_x;
      else                    pos = sum;
   end

   assign wave_skew = (pos < {2'b00, half});

   always_comb begin
      case (cfg_q.fn)
         FN_DIV2: wave = ~dcyc[0];
         FN_DIV4: wave = ~(dcyc[1] ^ dcyc[0]);
         FN_INV:  wave = (cnt >= half);
         default: wave = wave_skew;
      endcase
   end

   assign q = live & wave;
endmodule

// File: rtl/skew_phase_sel.sv
module skew_phase_sel
   import skew_sel_pkg::*;
#(
   parameter int N_LOW  = 44,
   parameter int N_MID  = 26,
   parameter int N_HIGH = 16
) (
   input  logic        tb_clk,
   input  logic        rst_n,
   input  logic [1:0]  range_sel,
   input  logic [1:0]  test_sel,
   input  logic        ref_in,
   input  logic [15:0] pair_sel,
   output logic [7:0]  clk_out
);
   localparam int NPAIR   = 4;
   localparam int N_MAX   = max3(N_LOW, N_MID, N_HIGH);
   localparam int CW      = $clog2(N_MAX + 1);
   localparam int MAX_OFS = 6;

   if ((N_LOW % 2) != 0 || (N_MID % 2) != 0 || (N_HIGH % 2) != 0) begin : g_bad_even
      $error("skew_phase_sel: every period must be even");
   end
   if (N_LOW / 2 <= MAX_OFS || N_MID / 2 <= MAX_OFS || N_HIGH / 2 <= MAX_OFS) begin : g_bad_span
      $error("skew_phase_sel: half period must exceed the largest offset");
   end

   logic          adv;
   logic [CW-1:0] cnt_w, ncur_w;
   logic          zero_pt, live;
   logic [1:0]    dcyc;

   skew_bypass_gate u_gate (
      .clk       (tb_clk),
      .rst_n     (rst_n),
      .test_code (test_sel),
      .ref_in    (ref_in),
      .adv       (adv)
   );

   skew_phase_ctr #(
      .N_LOW (N_LOW), .N_MID (N_MID), .N_HIGH (N_HIGH), .CW (CW)
   ) u_ctr (
      .clk        (tb_clk),
      .rst_n      (rst_n),
      .adv        (adv),
      .range_code (range_sel),
      .cnt        (cnt_w),
      .n_cur      (ncur_w),
      .zero_pt    (zero_pt),
      .live       (live),
      .dcyc       (dcyc)
   );

   for (genvar p = 0; p < NPAIR; p++) begin : g_pair
      localparam int K = (p < 2) ? KIND_FINE : ((p == 2) ? KIND_DIV4 : KIND_INV);
      logic q;
      skew_pair_gen #(.KIND (K), .CW (CW)) u_pg (
         .clk     (tb_clk),
         .rst_n   (rst_n),
         .load    (zero_pt),
         .hi_code (pair_sel[4*p+3 -: 2]),
         .lo_code (pair_sel[4*p+1 -: 2]),
         .cnt     (cnt_w),
         .n_cur   (ncur_w),
         .live    (live),
         .dcyc    (dcyc),
         .q       (q)
      );
      assign clk_out[2*p]   = q;
      assign clk_out[2*p+1] = q;
   end
endmodule

// File: rtl/skew_phase_sel_chk.sv
module skew_phase_sel_chk #(
   parameter int CW = 6
) (
   input logic          clk,
   input logic          rst_n,
   input logic [1:0]    test_sel,
   input logic          ref_in,
   input logic [7:0]    clk_out,
   input logic [CW-1:0] cnt,
   input logic [CW-1:0] n_cur
);
   // R1
   always_comb begin
      if (!rst_n) begin
         reset_quiet_chk: assert (clk_out == 8'h00);
      end
   end

   // R2
   cnt_bound_chk: assert property (@(posedge clk) disable iff (!rst_n)
      cnt < n_cur);

   // R2
   cnt_step_chk: assert property (@(posedge clk) disable iff (!rst_n)
      (cnt == $past(cnt)) || (cnt == $past(cnt) + CW'(1)) || (cnt == '0));

   // R10
   cfg_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
      (cnt != '0) |-> $stable(n_cur));

   // R11
   bypass_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
      ($past(test_sel) != 2'b00 && !$past(ref_in)) |-> $stable(clk_out));
endmodule

bind skew_phase_sel skew_phase_sel_chk #(.CW (CW)) u_chk (
   .clk      (tb_clk),
   .rst_n    (rst_n),
   .test_sel (test_sel),
   .ref_in   (ref_in),
   .clk_out  (clk_out),
   .cnt      (cnt_w),
   .n_cur    (ncur_w)
);

// File: tb/skew_phase_sel_bench.sv
module skew_phase_sel_bench;
   localparam int NL = 44, NM = 26, NH = 16;

   logic        clk = 1'b0;
   logic        rst_n = 1'b0;
   logic        ref_in = 1'b0;
   logic [1:0]  range_sel = 2'b01;
   logic [1:0]  test_sel = 2'b00;
   logic [15:0] pair_sel = {8{2'b01}};
   logic [7:0]  clk_out;

   always #5 clk = ~clk;

   skew_phase_sel u_skew_phase_sel (
      .tb_clk (clk), .rst_n (rst_n), .range_sel (range_sel), .test_sel (test_sel),
      .ref_in (ref_in), .pair_sel (pair_sel), .clk_out (clk_out)
   );

   int errors = 0;
   int checks = 0;
   bit cmp_on = 0;
   bit align_on = 0;
   string tag = "R1";

   // behavioural reference state
   int m_cnt = NM - 1, m_n = NM, m_live = 0, m_per = 0, m_refq = 0;
   int m_idx [4] = '{4, 4, 4, 4};

   function automatic int lvl(logic [1:0] c);
      return (c == 2'b00) ? 0 : ((c == 2'b10) ? 2 : 1);
   endfunction

   function automatic int period_of(logic [1:0] c);
      return (c == 2'b00) ? NL : ((c == 2'b10) ? NH : NM);
   endfunction

   always @(posedge clk) begin
      if (!rst_n) begin
         m_cnt = NM - 1; m_n = NM; m_live = 0; m_per = 0; m_refq = 0;
         for (int p = 0; p < 4; p++) m_idx[p] = 4;
      end else begin
         bit step;
         step = (test_sel == 2'b00) ? 1'b1 : (ref_in && m_refq == 0);
         m_refq = ref_in;
         if (step) begin
            if (m_cnt + 1 >= m_n) begin
               m_cnt = 0;
               if (m_live != 0) m_per = m_per + 1;
               m_n = period_of(range_sel);
               for (int p = 0; p < 4; p++)
                  m_idx[p] = 3 * lvl(pair_sel[4*p+3 -: 2]) + lvl(pair_sel[4*p+1 -: 2]);
            end else begin
               m_cnt = m_cnt + 1;
            end
            m_live = 1;
         end
      end
   end

   function automatic bit expect_out(int p);
      int h, k, ph;
      if (m_live == 0) return 1'b0;
      h = m_n / 2;
      if (p >= 2 && m_idx[p] == 0) return (m_per % 2) == 0;
      if (p == 2 && m_idx[p] == 8) return (m_per % 4 == 0) || (m_per % 4 == 3);
      if (p == 3 && m_idx[p] == 8) return m_cnt >= h;
      k  = (p < 2) ? m_idx[p] - 4 : 2 * (m_idx[p] - 4);
      ph = ((m_cnt - k) % m_n + m_n) % m_n;
      return ph < h;
   endfunction

   function automatic string req_of(int p);
      if (m_idx[p] == 4) return "R3";
      if (p >= 2 && m_idx[p] == 0) return "R6";
      if (p == 2 && m_idx[p] == 8) return "R7";
      if (p == 3 && m_idx[p] == 8) return "R8";
      return (p < 2) ? "R4" : "R5";
   endfunction

   // per-clock comparison against the reference
   always @(negedge clk) begin
      if (cmp_on) begin
         for (int p = 0; p < 4; p++) begin
            bit e;
            e = expect_out(p);
            checks++;
            if (clk_out[2*p] !== e) begin
               errors++;
               $display("FAIL %s [%s] pair %0d: got %b expected %b", req_of(p), tag, p + 1, clk_out[2*p], e);
            end
            checks++;
            if (clk_out[2*p+1] !== clk_out[2*p]) begin
               errors++;
               $display("FAIL R9 pair %0d: got %b expected %b", p + 1, clk_out[2*p+1], clk_out[2*p]);
            end
         end
      end
   end

   // R7 falling-edge alignment of divide-by-4 (pair 3) with divide-by-2 (pair 4)
   logic prev4 = 1'b0, prev6 = 1'b0;
   always @(negedge clk) begin
      if (align_on && prev4 && !clk_out[4]) begin
         checks++;
         if (!(prev6 && !clk_out[6])) begin
            errors++;
            $display("FAIL R7 alignment: got div2 %b->%b expected 1->0", prev6, clk_out[6]);
         end
      end
      prev4 = clk_out[4];
      prev6 = clk_out[6];
   end

   task automatic check(input string req, input logic got, input logic exp);
      checks++;
      if (got !== exp) begin
         errors++;
         $display("FAIL %s: got %b expected %b", req, got, exp);
      end
   endtask

   task automatic wait_rise();
      logic pv;
      bit   hit;
      pv = clk_out[0];
      do begin
         @(negedge clk);
         hit = !pv && clk_out[0];
         pv  = clk_out[0];
      end while (!hit);
   endtask

   task automatic set_all(input int idx);
      logic [3:0] c;
      c = {2'(idx / 3), 2'(idx % 3)};
      pair_sel = {c, c, c, c};
   endtask

   task automatic measure(input logic [1:0] rc, input int exp_n);
      int n;
      range_sel = rc;
      wait_rise();
      wait_rise();
      n = 0;
      begin
         logic pv;
         bit   hit;
         pv = clk_out[0];
         do begin
            @(negedge clk);
            n++;
            hit = !pv && clk_out[0];
            pv  = clk_out[0];
         end while (!hit);
      end
      checks++;
      if (n != exp_n) begin
         errors++;
         $display("FAIL R2 range %b: got %0d expected %0d", rc, n, exp_n);
      end
   endtask

   task automatic summary();
      $display("Result: errors=%0d of %0d checks", errors, checks);
   endtask

   initial begin
      repeat (150000) @(posedge clk);
      errors++;
      $display("FAIL watchdog: got hang expected finish");
      summary();
      $finish;
   end

   initial begin
      // R1: reset state
      repeat (3) @(negedge clk);
      check("R1 reset low", clk_out[0], 1'b0);
      check("R1 reset low all", (clk_out == 8'h00), 1'b1);
      cmp_on = 1;
      rst_n  = 1'b1;
      @(negedge clk);
      check("R1 first advance is zero point", clk_out[0], 1'b1);

      // R2: period per range code
      tag = "R2";
      measure(2'b00, NL);
      measure(2'b01, NM);
      measure(2'b10, NH);
      measure(2'b11, NM);

      // R4 R5 R6 R7 R8: every function code at every period
      tag = "R4";
      for (int r = 0; r < 3; r++) begin
         range_sel = (r == 0) ? 2'b10 : ((r == 1) ? 2'b01 : 2'b00);
         for (int idx = 0; idx < 9; idx++) begin
            set_all(idx);
            repeat (3 * NL) @(negedge clk);
         end
      end

      // R7: divide-by-4 on pair 3 next to divide-by-2 on pair 4
      tag = "R7";
      range_sel = 2'b10;
      pair_sel  = {4'b0000, 4'b1010, 4'b1000, 4'b0010};
      align_on  = 1;
      repeat (10 * NH) @(negedge clk);
      align_on  = 0;

      // R8 mixed with skewed pairs
      tag = "R8";
      pair_sel = {4'b1010, 4'b0001, 4'b0100, 4'b0110};
      repeat (4 * NH) @(negedge clk);

      // R10: mid-period change waits for the zero point
      tag = "R10";
      set_all(4);
      wait_rise();
      wait_rise();
      repeat (3) @(negedge clk);
      set_all(0);
      range_sel = 2'b00;
      @(negedge clk);
      check("R10 pair 1 keeps zero skew mid period", clk_out[0], 1'b1);
      check("R10 pair 3 not yet divided", clk_out[4], 1'b1);
      repeat (3 * NH) @(negedge clk);

      // R11: bypass, reference edges step the counter
      tag = "R11";
      range_sel = 2'b10;
      set_all(4);
      repeat (2 * NL) @(negedge clk);
      for (int t = 1; t < 4; t++) begin
         test_sel = 2'(t);
         for (int e = 0; e < 2 * NH; e++) begin
            ref_in = 1'b1;
            repeat (2) @(negedge clk);
            ref_in = 1'b0;
            repeat (3) @(negedge clk);
         end
      end
      test_sel = 2'b00;
      repeat (2 * NH) @(negedge clk);

      summary();
      $finish;
   end
endmodule